// File: doc/BRIEF.md
# Slope-Aware Three-Level Input Slicer

This block turns a stream of sampled analogue readings into a three-valued logic level: logic low, logic high or unknown. Each reading is given in millivolts on a sample bus, and a valid strobe marks it as accepted. A reading above the upper threshold drives the level high, and a reading below the lower threshold drives it low. A reading between the two thresholds is judged by the direction of travel since the previous accepted reading.

When the signal is still moving in the direction of the transition in progress, the level stays where it was. A clean rise goes straight from low to high, and a clean fall goes straight from high to low, with no unknown in between. The level becomes unknown only when, inside the band, the signal turns back against the level it last held. That is a real fluctuation and not a transition.

The block makes one decision per accepted reading, with a single register stage. A one-cycle change strobe marks each update of the level. The two thresholds, the sample width and the signedness of the bus are parameters.

Top module: `tri_level_slicer`

## Requirements
- R1: `level_o` uses the encoding 2'b00 = low, 2'b01 = high and 2'b10 = unknown, and never shows 2'b11. While `rst_ni` is low, `level_o` is 2'b10 and `change_o` is 0. The remembered previous reading resets to 0.
- R2: An accepted reading strictly greater than HIGH_MV (3500 by default) sets `level_o` to 2'b01 on the clock edge that accepts it.
- R3: An accepted reading strictly less than LOW_MV (1500 by default) sets `level_o` to 2'b00 on the clock edge that accepts it.
- R4: An accepted reading inside the band, while the level is low and the reading is lower than the previous accepted reading, sets the level to unknown.
- R5: An accepted reading inside the band, while the level is high and the reading is higher than the previous accepted reading, sets the level to unknown.
- R6: An accepted reading inside the band whose slope follows the current level keeps that level. This includes a reading equal to the previous one. A monotonic crossing never passes through unknown.
- R7: `change_o` is high for exactly the one cycle after an edge at which `level_o` took a new value. It stays low when an accepted reading leaves the level unchanged.
- R8: A cycle with `smp_valid_i` low changes neither the level nor the remembered previous reading, whatever `smp_data_i` carries.
- R9: A reading exactly equal to HIGH_MV or LOW_MV counts as inside the band.
- R10: While the level is unknown, an accepted reading inside the band keeps it unknown, whatever the slope.
- R11: With SIGNED_IN = 1 (the default), the sample bus is two's complement, so a negative reading counts as below LOW_MV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Marks `smp_data_i` as an accepted reading this cycle |
| smp_data_i | input | SAMPLE_W | Reading in millivolts |
| level_o | output | 2 | Current level: 00 low, 01 high, 10 unknown |
| change_o | output | 1 | One-cycle pulse after the level changes |

## Verification
A reading accepted at a rising edge shows its level on `level_o` right after that edge, and `change_o` is high for that same following cycle only. The bench drives each reading just after a falling edge and compares both outputs at the next falling edge. That falling edge lies after exactly one active edge, so every comparison sees the result of the previous reading and nothing later. The vectors run back to back, so a row that leaves the level unchanged also shows that the strobe from the row before has dropped. Cycles with the strobe low carry extreme readings, and the next accepted reading exposes any leak of them into the slope memory.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_HIGH = 2'b01,
      LVL_UNK  = 2'b10
   } level_e;

endpackage

// File: rtl/slicer_band.sv
// Threshold comparison of one reading against the two band edges.
module slicer_band #(
   parameter int SAMPLE_W  = 16,
   parameter bit SIGNED_IN = 1'b1,
   parameter int HIGH_MV   = 3500,
   parameter int LOW_MV    = 1500
) (
   input  logic [SAMPLE_W-1:0] smp_i,
   output logic                above_o,
   output logic                below_o
);
   localparam logic [SAMPLE_W-1:0] HI_V = SAMPLE_W'(HIGH_MV);
   localparam logic [SAMPLE_W-1:0] LO_V = SAMPLE_W'(LOW_MV);

   generate
      if (SIGNED_IN) begin : g_signed
         assign above_o = $signed(smp_i) > $signed(HI_V);
         assign below_o = $signed(smp_i) < $signed(LO_V);
      end else begin : g_unsigned
         assign above_o = smp_i > HI_V;
         assign below_o = smp_i < LO_V;
      end
   endgenerate
endmodule

// File: rtl/slicer_slope.sv
// Holds the last accepted reading and reports the direction of the new one.
module slicer_slope #(
   parameter int SAMPLE_W  = 16,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                valid_i,
   input  logic [SAMPLE_W-1:0] smp_i,
   output logic                rise_o,
   output logic                fall_o
);
   logic [SAMPLE_W-1:0] prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      prev_q <= '0;
      else if (valid_i) prev_q <= smp_i;
   end

   generate
      if (SIGNED_IN) begin : g_signed
         assign rise_o = $signed(smp_i) > $signed(prev_q);
         assign fall_o = $signed(smp_i) < $signed(prev_q);
      end else begin : g_unsigned
         assign rise_o = smp_i > prev_q;
         assign fall_o = smp_i < prev_q;
      end
   endgenerate
endmodule

// File: rtl/slicer_decide.sv
// Next-level decision from the threshold flags, the slope and the current level.
module slicer_decide
   import slicer_pkg::*;
(
   input  logic   above_i,
   input  logic   below_i,
   input  logic   rise_i,
   input  logic   fall_i,
   input  level_e cur_i,
   output level_e nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      if (above_i)                          nxt_o = LVL_HIGH;
      else if (below_i)                     nxt_o = LVL_LOW;
      else if (cur_i == LVL_LOW  && fall_i) nxt_o = LVL_UNK;
      else if (cur_i == LVL_HIGH && rise_i) nxt_o = LVL_UNK;
   end
endmodule

// File: rtl/tri_level_slicer.sv
module tri_level_slicer
   import slicer_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter bit SIGNED_IN = 1'b1,
   parameter int HIGH_MV   = 3500,
   parameter int LOW_MV    = 1500
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   output logic [1:0]          level_o,
   output logic                change_o
);
   localparam int MAG_W   = SIGNED_IN ? SAMPLE_W - 1 : SAMPLE_W;
   localparam longint MAX_MV = (longint'(1) << MAG_W) - 1;

   generate
      if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_width
         $error("tri_level_slicer: SAMPLE_W out of range");
      end
      if (LOW_MV >= HIGH_MV) begin : g_bad_order
         $error("tri_level_slicer: LOW_MV must be below HIGH_MV");
      end
      if (longint'(HIGH_MV) > MAX_MV || (!SIGNED_IN && LOW_MV < 0)) begin : g_bad_range
         $error("tri_level_slicer: threshold not representable");
      end
   endgenerate

   logic   above, below, rise, fall;
   level_e cur_q, nxt;
   logic   chg_q;

   slicer_band #(
      .SAMPLE_W (SAMPLE_W),
      .SIGNED_IN(SIGNED_IN),
      .HIGH_MV  (HIGH_MV),
      .LOW_MV   (LOW_MV)
   ) band_i (
      .smp_i  (smp_data_i),
      .above_o(above),
      .below_o(below)
   );

   slicer_slope #(
      .SAMPLE_W (SAMPLE_W),
      .SIGNED_IN(SIGNED_IN)
   ) slope_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(smp_valid_i),
      .smp_i  (smp_data_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   slicer_decide decide_i (
      .above_i(above),
      .below_i(below),
      .rise_i (rise),
      .fall_i (fall),
      .cur_i  (cur_q),
      .nxt_o  (nxt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q <= LVL_UNK;
         chg_q <= 1'b0;
      end else begin
         chg_q <= smp_valid_i && (nxt != cur_q);
         if (smp_valid_i) cur_q <= nxt;
      end
   end

   assign level_o  = cur_q;
   assign change_o = chg_q;
endmodule

// File: rtl/slicer_chk.sv
module slicer_chk #(
   parameter int SAMPLE_W  = 16,
   parameter bit SIGNED_IN = 1'b1,
   parameter int HIGH_MV   = 3500,
   parameter int LOW_MV    = 1500
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                smp_valid_i,
   input logic [SAMPLE_W-1:0] smp_data_i,
   input logic [1:0]          level_o,
   input logic                change_o
);
   logic signed [32:0] sx;
   assign sx = SIGNED_IN ? 33'(signed'(smp_data_i)) : 33'({1'b0, smp_data_i});

   // R1
   legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_o != 2'b11);

   // R2
   above_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_valid_i && sx > 33'(HIGH_MV)) |=> level_o == 2'b01);

   // R3
   below_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_valid_i && sx < 33'(LOW_MV)) |=> level_o == 2'b00);

   // R7
   strobe_means_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      change_o |-> level_o != $past(level_o));

   // R7
   change_means_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o != $past(level_o)) |-> change_o);

   // R8
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_valid_i |=> ($stable(level_o) && !change_o));
endmodule

bind tri_level_slicer slicer_chk #(
   .SAMPLE_W (SAMPLE_W),
   .SIGNED_IN(SIGNED_IN),
   .HIGH_MV  (HIGH_MV),
   .LOW_MV   (LOW_MV)
) chk_i (.*);

// File: tb/tri_level_slicer_tb_top.sv
`timescale 1ns/1ps
module tri_level_slicer_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        smp_valid_i = 1'b0;
   logic [15:0] smp_data_i = '0;
   logic [1:0]  level_o;
   logic        change_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk_i = ~clk_i;

   tri_level_slicer dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_valid_i(smp_valid_i),
      .smp_data_i (smp_data_i),
      .level_o    (level_o),
      .change_o   (change_o)
   );

   localparam int NV = 23;
   // rows: valid, reading (mV), expected level, expected strobe, requirement
   localparam int V_VLD [NV] = '{1,1,1,1,1, 1,1,1,1,1, 1,1,1,1,1, 1,1,1,1,1, 0,0,1};
   localparam int V_SMP [NV] = '{
      1000, 2000, 3000, 4000, 3000,   // R3 R6 R6 R2 R6
      3200, 3100, 1000, 2500, 2400,   // R5 R10 R3 R6 R4
      2400, 3500, 3501, 3501, 1500,   // R10 R9 R2 R7 R9
      1500, 1499, -200, 1600, 1600,   // R6 R3 R11 R6 R6
      5000, 1000, 1550};              // R8 R8 R8(R4 against 1600, not 1000)
   localparam int V_LVL [NV] = '{0,0,0,1,1, 2,2,0,0,2, 2,2,1,1,1, 1,0,0,0,0, 0,0,2};
   localparam int V_CHG [NV] = '{1,0,0,1,0, 1,0,1,0,1, 0,0,1,0,0, 0,1,0,0,0, 0,0,1};
   localparam int V_REQ [NV] = '{3,6,6,2,6, 5,10,3,6,4, 10,9,2,7,9, 6,3,11,6,6, 8,8,8};

   task automatic check(input string req, input logic [1:0] el, input logic ec);
      n_cmp++;
      if (level_o !== el || change_o !== ec) begin
         n_bad++;
         $display("FAIL %s: level=%b change=%b expected level=%b change=%b",
                  req, level_o, change_o, el, ec);
      end
   endtask

   task automatic step(input logic v, input int mv);
      smp_valid_i = v;
      smp_data_i  = 16'(mv);
      @(posedge clk_i);
      @(negedge clk_i);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      check("R1 reset", 2'b10, 1'b0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 idle after reset", 2'b10, 1'b0);

      for (int i = 0; i < NV; i++) begin
         step(V_VLD[i] != 0, V_SMP[i]);
         check($sformatf("R%0d row %0d", V_REQ[i], i), 2'(V_LVL[i]), V_CHG[i] != 0);
      end

      // R7: strobe drops when inputs go idle; R8: level held
      step(1'b0, 0);
      check("R7 strobe one cycle", 2'b10, 1'b0);
      step(1'b0, 9000);
      check("R8 idle reading ignored", 2'b10, 1'b0);

      // R1: reset mid-run returns to unknown
      rst_ni = 1'b0;
      step(1'b1, 4000);
      check("R1 reset mid-run", 2'b10, 1'b0);
      rst_ni = 1'b1;
      // R10: first in-band reading after reset keeps unknown
      step(1'b1, 2000);
      check("R10 band from unknown", 2'b10, 1'b0);
      // R3 / R7
      step(1'b1, 100);
      check("R3 low after reset", 2'b00, 1'b1);
      // R6: monotonic rise through band then above
      step(1'b1, 1800);
      check("R6 rise hold low", 2'b00, 1'b0);
      step(1'b1, 3300);
      check("R6 rise hold low", 2'b00, 1'b0);
      step(1'b1, 3600);
      check("R2 reach high", 2'b01, 1'b1);
      smp_valid_i = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk_i);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule